// File: doc/BRIEF.md
# Normalizing Barrel Shifter Stage

This block takes one 32-bit word per accepted transfer and produces one 16-bit half of a shifted copy of it, together with a 5-bit leading-digit count. Three shift behaviours are offered. The word can be rotated left. It can be shifted left with zeros entering at the bottom. It can be shifted right with a sign bit entering at the top. The right shift is requested by reading the direction bit as the sign of a 6-bit two's complement amount formed with the 5-bit code. Taken together, the fill modes pick any 32-bit window out of a 96-bit string made of 32 sign copies, the word itself, and 32 zeros.

The leading-digit count is computed on the word after each bit is XORed with the sign input. This lets both positive values and negative two's complement mantissas be normalized. When the normalize request is set, that count replaces the external shift code. A left fill shift then brings the first significant digit to bit 31.

Data enters and leaves through valid/ready handshakes with a single result register. The input side accepts a new item in the same cycle that the held result is taken. A held result does not change while the consumer stalls. An output enable gates what is visible at the output: while it is low, the data lines read zero, the output valid is low, and the held item waits.

Top module: `bshift_norm_top`

## Requirements
- R1: With `in_wrap`=1, the 32-bit shift result is `in_word` rotated left by the effective code. `in_right` has no effect on the result.
- R2: With `in_wrap`=0 and `in_right`=0, the result is `in_word` shifted left by the effective code, and the vacated low bits are 0.
- R3: With `in_wrap`=0 and `in_right`=1, the result is `in_word` shifted right by 32 minus the effective code, and the vacated high bits equal `in_sign`. Code 0 gives all bits equal to `in_sign`, and code 31 gives a right shift by one.
- R4: `in_hi`=1 puts bits 31..16 of the shift result on `out_data`, and `in_hi`=0 puts bits 15..0 there.
- R5: `out_code` equals 31 minus the index of the highest set bit of `in_word` XOR {32{`in_sign`}}, and equals 31 when that word is all zero. `in_sign` does not alter the word that is shifted.
- R6: With `in_norm`=1, the R5 count is used as the effective code in place of `in_code`.
- R7: While `oe`=0, `out_data` is 0 and `out_valid` is 0. The held item is neither lost nor consumed, and it reappears when `oe` returns to 1.
- R8: An item transfers on a clock edge when valid and ready are both 1. While `out_valid`=1 and `out_ready`=0, `out_code` and `out_data` stay unchanged and `in_ready` is 0. `in_ready` is 1 when the stage is empty, or when its result is taken in that cycle. Results leave in acceptance order.
- R9: After reset, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input item present |
| in_ready | output | 1 | Stage can take an item this cycle |
| in_word | input | 32 | Word to shift and encode |
| in_sign | input | 1 | Fill value for right shifts and XOR mask for the encoder |
| in_code | input | 5 | Left shift amount (two's complement reading gives right) |
| in_right | input | 1 | In fill mode, sign bit of the 6-bit shift amount |
| in_wrap | input | 1 | 1 = rotate, 0 = fill |
| in_norm | input | 1 | Use the leading-digit count as the shift code |
| in_hi | input | 1 | 1 = upper half, 0 = lower half of the result |
| oe | input | 1 | Output enable |
| out_valid | output | 1 | Result present and enabled |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | 16 | Selected half of the shift result |
| out_code | output | 5 | Leading-digit count of the sign-masked word |

## Verification
The two functions that most often fall in the same cycle are taking a finished result at the output and capturing a new word at the input. Both depend on `in_ready` being derived from `out_ready` and `oe` in the same cycle. The bench keeps `in_valid` high almost all the time while it randomizes `out_ready` and drops `oe` at random. This forces many cycles where one item leaves and the next enters on the same edge. The scoreboard then judges these cycles: every result must arrive exactly once, in order, and must match a window model of the 96-bit fill string, whatever mix of stall and enable preceded it.

// File: rtl/bshift_pkg.sv
package bshift_pkg;
  typedef enum logic [1:0] {
    SH_ROTATE = 2'd0,
    SH_LEFT   = 2'd1,
    SH_RIGHT  = 2'd2
  } sh_mode_e;

  function automatic sh_mode_e pick_mode(input logic wrap, input logic right);
    if (wrap) return SH_ROTATE;
    else if (right) return SH_RIGHT;
    else return SH_LEFT;
  endfunction
endpackage

// File: rtl/bshift_lead_enc.sv
module bshift_lead_enc #(
  parameter int W  = 32,
  parameter int CW = $clog2(W)
) (
  input  logic [W-1:0]  word,
  input  logic          sign,
  output logic [CW-1:0] count
);
  logic [W-1:0] masked;

  for (genvar g = 0; g < W; g++) begin : g_mask
    assign masked[g] = word[g] ^ sign;
  end

  always_comb begin
    count = CW'(W - 1);
    for (int i = 0; i < W; i++) begin
      if (masked[i]) count = CW'(W - 1 - i);
    end
  end
endmodule

// File: rtl/bshift_core.sv
module bshift_core
  import bshift_pkg::*;
#(
  parameter int W  = 32,
  parameter int CW = $clog2(W)
) (
  input  logic [W-1:0]  word,
  input  logic          sign,
  input  logic [CW-1:0] amt,
  input  sh_mode_e      mode,
  output logic [W-1:0]  result
);
  localparam int OW = CW + 2;

  logic [3*W-1:0] span;
  logic [2*W-1:0] twin;
  logic [OW-1:0]  off;
  logic [3*W-1:0] span_sh;
  logic [2*W-1:0] twin_sh;

  assign span = {{W{sign}}, word, {W{1'b0}}};
  assign twin = {word, word};

  always_comb begin
    case (mode)
      SH_RIGHT: off = OW'(2 * W) - OW'(amt);
      default:  off = OW'(W) - OW'(amt);
    endcase
  end

  assign span_sh = span >> off;
  assign twin_sh = twin >> off;

  always_comb begin
    if (mode == SH_ROTATE) result = twin_sh[W-1:0];
    else result = span_sh[W-1:0];
  end
endmodule

// File: rtl/bshift_norm_top.sv
module bshift_norm_top
  import bshift_pkg::*;
#(
  parameter int W = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [W-1:0]         in_word,
  input  logic                 in_sign,
  input  logic [$clog2(W)-1:0] in_code,
  input  logic                 in_right,
  input  logic                 in_wrap,
  input  logic                 in_norm,
  input  logic                 in_hi,
  input  logic                 oe,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [W/2-1:0]       out_data,
  output logic [$clog2(W)-1:0] out_code
);
  localparam int CW = $clog2(W);
  localparam int H  = W / 2;

  logic [CW-1:0] lead_cnt;
  logic [CW-1:0] eff_amt;
  logic [W-1:0]  shifted;
  logic [H-1:0]  half_sel;
  sh_mode_e      mode;

  logic          full;
  logic [H-1:0]  q_data;
  logic [CW-1:0] q_code;
  logic          take_out;
  logic          take_in;

  bshift_lead_enc #(.W(W), .CW(CW)) u_enc (
    .word  (in_word),
    .sign  (in_sign),
    .count (lead_cnt)
  );

  assign eff_amt = in_norm ? lead_cnt : in_code;
  assign mode    = pick_mode(in_wrap, in_right);

  bshift_core #(.W(W), .CW(CW)) u_core (
    .word   (in_word),
    .sign   (in_sign),
    .amt    (eff_amt),
    .mode   (mode),
    .result (shifted)
  );

  assign half_sel = in_hi ? shifted[W-1:H] : shifted[H-1:0];

  assign take_out = full & oe & out_ready;
  assign in_ready = ~full | take_out;
  assign take_in  = in_valid & in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      full   <= 1'b0;
      q_data <= '0;
      q_code <= '0;
    end else begin
      if (take_in) begin
        full   <= 1'b1;
        q_data <= half_sel;
        q_code <= lead_cnt;
      end else if (take_out) begin
        full <= 1'b0;
      end
    end
  end

  assign out_valid = full & oe;
  assign out_data  = oe ? q_data : '0;
  assign out_code  = q_code;
endmodule

// File: rtl/bshift_norm_chk.sv
module bshift_norm_chk #(
  parameter int W = 32
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 in_valid,
  input logic                 in_ready,
  input logic                 oe,
  input logic                 out_valid,
  input logic                 out_ready,
  input logic [W/2-1:0]       out_data,
  input logic [$clog2(W)-1:0] out_code
);
  p_oe_blank_r7: assert property (@(posedge clk) disable iff (rst)
    !oe |-> (out_data == '0 && !out_valid));

  p_code_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> $stable(out_code));

  p_valid_keep_r8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid || !oe));

  p_stall_ready_r8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |-> !in_ready);

  p_data_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready && oe) |=> (oe -> $stable(out_data)));
endmodule

bind bshift_norm_top bshift_norm_chk #(.W(W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .oe        (oe),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .out_code  (out_code)
);

// File: tb/sim_bshift_norm_top.sv
module sim_bshift_norm_top;
  localparam int W  = 32;
  localparam int CW = 5;
  localparam int H  = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [W-1:0]  in_word = '0;
  logic          in_sign = 1'b0;
  logic [CW-1:0] in_code = '0;
  logic          in_right = 1'b0;
  logic          in_wrap = 1'b0;
  logic          in_norm = 1'b0;
  logic          in_hi = 1'b0;
  logic          oe = 1'b1;
  logic          out_valid;
  logic          out_ready = 1'b0;
  logic [H-1:0]  out_data;
  logic [CW-1:0] out_code;

  int n_chk = 0;
  int n_bad = 0;
  int n_sent = 0;
  int n_got = 0;
  bit done = 1'b0;

  typedef struct {
    logic [H-1:0]  data;
    logic [CW-1:0] code;
    string         tag;
  } exp_t;
  exp_t sb[$];

  always #2 clk = ~clk;

  bshift_norm_top #(.W(W)) u0 (.*);

  function automatic logic [CW-1:0] ref_count(logic [W-1:0] x, logic s);
    for (int i = W - 1; i >= 0; i--)
      if ((x[i] ^ s) == 1'b1) return CW'(W - 1 - i);
    return CW'(W - 1);
  endfunction

  function automatic logic [W-1:0] ref_shift(logic [W-1:0] x, logic s,
      logic [CW-1:0] c, logic right, logic wrap);
    logic [W-1:0] r;
    int sh;
    for (int i = 0; i < W; i++) begin
      if (wrap) r[i] = x[(i - int'(c) + W) % W];
      else begin
        sh = right ? int'(c) - W : int'(c);
        if (i - sh > W - 1) r[i] = s;
        else if (i - sh < 0) r[i] = 1'b0;
        else r[i] = x[i - sh];
      end
    end
    return r;
  endfunction

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic send(logic [W-1:0] x, logic s, logic [CW-1:0] c,
      logic right, logic wrap, logic norm, logic hi);
    exp_t e;
    logic [CW-1:0] cnt;
    logic [W-1:0] full_r;
    @(negedge clk);
    in_valid = 1'b1; in_word = x; in_sign = s; in_code = c;
    in_right = right; in_wrap = wrap; in_norm = norm; in_hi = hi;
    forever begin
      #1;
      if (in_ready) begin
        cnt = ref_count(x, s);
        full_r = ref_shift(x, s, norm ? cnt : c, right, wrap);
        e.data = hi ? full_r[W-1:H] : full_r[H-1:0];
        e.code = cnt;
        e.tag = norm ? "R6" : (wrap ? "R1" : (right ? "R3" : "R2"));
        sb.push_back(e);
        n_sent++;
        @(posedge clk);
        break;
      end
      @(negedge clk);
    end
  endtask

  // monitor: drives consumer side, pops and compares
  initial begin : monitor
    logic [H-1:0] held_d;
    logic [CW-1:0] held_c;
    bit was_stall;
    exp_t e;
    was_stall = 1'b0;
    @(negedge clk);
    while (rst) @(negedge clk);
    forever begin
      @(negedge clk);
      out_ready = ($urandom_range(0, 99) < 65);
      oe = ($urandom_range(0, 99) < 85);
      #1;
      if (!oe) begin
        check(out_data == '0 && !out_valid, "R7 oe low blanks output",
              {15'd0, out_valid, out_data}, 32'd0);
      end
      if (was_stall && oe && out_valid) begin
        check(out_data == held_d && out_code == held_c, "R8 held result stable",
              {11'd0, out_code, out_data}, {11'd0, held_c, held_d});
      end
      if (out_valid && !out_ready) begin
        check(!in_ready, "R8 no accept during stall", {31'd0, in_ready}, 32'd0);
        held_d = out_data; held_c = out_code; was_stall = 1'b1;
      end else if (oe) begin
        was_stall = 1'b0;
      end
      if (out_valid && out_ready) begin
        if (sb.size() == 0) begin
          check(1'b0, "R8 unexpected result", {16'd0, out_data}, 32'd0);
        end else begin
          e = sb.pop_front();
          check(out_data == e.data, {e.tag, "/R4 data"}, {16'd0, out_data}, {16'd0, e.data});
          check(out_code == e.code, "R5 code", {27'd0, out_code}, {27'd0, e.code});
          n_got++;
        end
        was_stall = 1'b0;
      end
    end
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin : driver
    logic [W-1:0] x;
    repeat (4) @(negedge clk);
    #1;
    check(!out_valid && in_ready, "R9 reset state", {30'd0, out_valid, in_ready}, 32'd1);
    rst = 1'b0;
    #1;
    check(!out_valid && in_ready, "R9 idle after reset", {30'd0, out_valid, in_ready}, 32'd1);
    // R1 rotate, direction bit ignored
    send(32'h8000_0001, 1'b0, 5'd1, 1'b0, 1'b1, 1'b0, 1'b0);
    send(32'h8000_0001, 1'b1, 5'd1, 1'b1, 1'b1, 1'b0, 1'b1);
    send(32'h1234_5678, 1'b0, 5'd31, 1'b1, 1'b1, 1'b0, 1'b0);
    // R2 left fill
    send(32'hFFFF_FFFF, 1'b1, 5'd31, 1'b0, 1'b0, 1'b0, 1'b1);
    send(32'hFFFF_FFFF, 1'b1, 5'd17, 1'b0, 1'b0, 1'b0, 1'b0);
    send(32'hDEAD_BEEF, 1'b0, 5'd0, 1'b0, 1'b0, 1'b0, 1'b1);
    // R3 right fill, code 0 all sign, code 31 right by one
    send(32'h0000_0000, 1'b1, 5'd0, 1'b1, 1'b0, 1'b0, 1'b0);
    send(32'h8000_0000, 1'b1, 5'd31, 1'b1, 1'b0, 1'b0, 1'b1);
    send(32'h8000_0000, 1'b0, 5'd16, 1'b1, 1'b0, 1'b0, 1'b0);
    // R5 encoder corners
    send(32'h0000_0000, 1'b0, 5'd3, 1'b0, 1'b0, 1'b0, 1'b0);
    send(32'hFFFF_FFFF, 1'b1, 5'd3, 1'b0, 1'b0, 1'b0, 1'b0);
    send(32'h0000_0001, 1'b0, 5'd0, 1'b0, 1'b1, 1'b0, 1'b0);
    // R6 normalize single bits and negatives
    for (int b = 0; b < W; b++) begin
      send(32'h1 << b, 1'b0, 5'd0, 1'b0, 1'b0, 1'b1, b[0]);
      send(~(32'h1 << b), 1'b1, 5'd0, 1'b0, 1'b0, 1'b1, b[1]);
    end
    // random mix
    for (int k = 0; k < 400; k++) begin
      x = $urandom();
      if (k % 7 == 0) x = x >> $urandom_range(0, 31);
      send(x, 1'($urandom()), 5'($urandom()), 1'($urandom()), 1'($urandom()),
           ($urandom_range(0, 3) == 0), 1'($urandom()));
    end
    @(negedge clk);
    in_valid = 1'b0;
    while (sb.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
    check(n_got == n_sent, "R8 every item delivered once", n_got, n_sent);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule